// File: doc/BRIEF.md
# Receive Packet Status Queue

This block keeps one 16-bit status word for each received packet that the host has not yet taken. When a frame ends, the frame receiver presents its byte count and a 4-bit error class. The block turns these into a status word and appends it to a small ordered queue. The host always sees the oldest word on `head_word`. When the host has finished with that packet, it removes the word with a discard command. A receive-reset command empties the whole queue at once.

When the queue holds `DEPTH` words (eight by default), `q_full` goes high. While it is high, further end-of-frame pushes are dropped. The stored words stay as they are until the host removes one. An empty queue shows a marker word with only the top bit set, so the host can tell "no packet" from a real status. A separate flag, `rx_busy`, shows when a frame is in progress between the start and end strobes.

Top module: `rxstat_queue`

## Requirements
- R1: After reset, `head_word` is 16'h8000, and `q_full` and `rx_busy` are low.
- R2: A stored word has bit 15 = 0, the error class in bits 14..11 and the byte count in bits 10..0. `head_word` shows the oldest stored word, so words leave in arrival order.
- R3: The error classes 4'b1000 (overrun), 4'b1001 (oversize), 4'b1011 (runt), 4'b1100 (alignment), 4'b1101 (CRC) and 4'b0010 (dribble) are stored unchanged. Every other value is stored as 4'b0000.
- R4: A byte count above 1514 is stored as 1514.
- R5: With `DEPTH` words queued, `q_full` is high. A push made while full is dropped, and `head_word` and the stored words stay unchanged.
- R6: A command with `cmd_op` = 5'd8 removes the head word. If the queue was full, `q_full` falls on the next cycle.
- R7: A discard command on an empty queue has no effect. Later pushes behave as on a fresh queue.
- R8: A command with `cmd_op` = 5'd5 clears every queued word. `head_word` then returns to 16'h8000 and `q_full` goes low.
- R9: `rx_busy` rises the cycle after `mac_sof` and falls the cycle after `mac_eof`. If both strobes arrive in the same cycle, `rx_busy` is high afterwards.
- R10: When the queue is not full, a push and a discard in the same cycle both take effect.
- R11: Command opcodes other than 5 and 8 leave the queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mac_sof | input | 1 | Start-of-frame strobe from the frame receiver |
| mac_eof | input | 1 | End-of-frame strobe; pushes one status word |
| mac_err | input | 4 | Error class of the ending frame |
| mac_len | input | 11 | Byte count of the ending frame |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 5 | Host command opcode (5 = receive reset, 8 = discard head) |
| head_word | output | 16 | Oldest status word, or 16'h8000 when empty |
| q_full | output | 1 | Queue holds DEPTH words; new pushes are dropped |
| rx_busy | output | 1 | A frame is between its start and end strobes |

## Verification
Frames are pushed with every recognised error class, with one unrecognised class, and with a count above 1514. This separates correct class filtering and length clamping from plain pass-through. The queue is filled to capacity and pushed once more, which shows whether the overflow word is dropped or overwrites a stored one. Discards are issued on a full queue, on an empty queue, and in the same cycle as a push, which exposes faults in the counter and pointer arithmetic. A receive reset with words pending, followed by a fresh push, confirms that both pointers return to the start.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
    localparam int LEN_W  = 11;
    localparam int WORD_W = 16;
    localparam int OP_W   = 5;

    localparam logic [LEN_W-1:0]  LEN_CAP    = 11'd1514;
    localparam logic [OP_W-1:0]   OP_RXRESET = 5'd5;
    localparam logic [OP_W-1:0]   OP_DISCARD = 5'd8;
    localparam logic [WORD_W-1:0] EMPTY_WORD = 16'h8000;

    typedef enum logic [3:0] {
        CLS_NONE    = 4'b0000,
        CLS_DRIBBLE = 4'b0010,
        CLS_OVERRUN = 4'b1000,
        CLS_OVERSZ  = 4'b1001,
        CLS_RUNT    = 4'b1011,
        CLS_ALIGN   = 4'b1100,
        CLS_CRC     = 4'b1101
    } err_cls_e;

    typedef struct packed {
        logic             pend;
        err_cls_e         cls;
        logic [LEN_W-1:0] len;
    } stat_word_t;
endpackage

// File: rtl/rxstat_pack.sv
module rxstat_pack
    import rxstat_pkg::*;
(
    input  logic [3:0]       err_in,
    input  logic [LEN_W-1:0] len_in,
    output stat_word_t       word
);
    always_comb begin
        word.pend = 1'b0;
        unique case (err_in)
            4'b0010: word.cls = CLS_DRIBBLE;
            4'b1000: word.cls = CLS_OVERRUN;
            4'b1001: word.cls = CLS_OVERSZ;
            4'b1011: word.cls = CLS_RUNT;
            4'b1100: word.cls = CLS_ALIGN;
            4'b1101: word.cls = CLS_CRC;
            default: word.cls = CLS_NONE;
        endcase
        word.len = (len_in > LEN_CAP) ? LEN_CAP : len_in;
    end
endmodule

// File: rtl/rxstat_cmd.sv
module rxstat_cmd
    import rxstat_pkg::*;
(
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    output logic            discard,
    output logic            flush
);
    always_comb begin
        discard = cmd_valid && (cmd_op == OP_DISCARD);
        flush   = cmd_valid && (cmd_op == OP_RXRESET);
    end
endmodule

// File: rtl/rxstat_store.sv
module rxstat_store
    import rxstat_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  stat_word_t push_word,
    input  logic       pop,
    input  logic       flush,
    output stat_word_t head,
    output logic       empty,
    output logic       full,
    output logic [$clog2(DEPTH+1)-1:0] occ
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t       ctl_d, ctl_q;
    stat_word_t mem_d [DEPTH];
    stat_word_t mem_q [DEPTH];
    logic       do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ctl_d   = ctl_q;
        mem_d   = mem_q;
        do_push = push && (ctl_q.cnt != CNT_MAX);
        do_pop  = pop && (ctl_q.cnt != '0);
        if (flush) begin
            ctl_d = '0;
        end else begin
            if (do_push) begin
                mem_d[ctl_q.wr] = push_word;
                ctl_d.wr        = step(ctl_q.wr);
            end
            if (do_pop) begin
                ctl_d.rd = step(ctl_q.rd);
            end
            unique case ({do_push, do_pop})
                2'b10:   ctl_d.cnt = ctl_q.cnt + 1'b1;
                2'b01:   ctl_d.cnt = ctl_q.cnt - 1'b1;
                default: ctl_d.cnt = ctl_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[gi] <= '0;
            end else begin
                mem_q[gi] <= mem_d[gi];
            end
        end
    end

    always_comb begin
        head  = mem_q[ctl_q.rd];
        empty = (ctl_q.cnt == '0);
        full  = (ctl_q.cnt == CNT_MAX);
        occ   = ctl_q.cnt;
    end
endmodule

// File: rtl/rxstat_queue.sv
module rxstat_queue
    import rxstat_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mac_sof,
    input  logic              mac_eof,
    input  logic [3:0]        mac_err,
    input  logic [LEN_W-1:0]  mac_len,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    output logic [WORD_W-1:0] head_word,
    output logic              q_full,
    output logic              rx_busy
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic busy;
    } top_t;

    top_t       st_d, st_q;
    stat_word_t packed_word;
    stat_word_t head_entry;
    logic       discard_w, flush_w, empty_w;
    logic [CNT_W-1:0] occ_w;

    rxstat_pack u_pack (
        .err_in (mac_err),
        .len_in (mac_len),
        .word   (packed_word)
    );

    rxstat_cmd u_cmd (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .discard   (discard_w),
        .flush     (flush_w)
    );

    rxstat_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (mac_eof),
        .push_word (packed_word),
        .pop       (discard_w),
        .flush     (flush_w),
        .head      (head_entry),
        .empty     (empty_w),
        .full      (q_full),
        .occ       (occ_w)
    );

    always_comb begin
        st_d = st_q;
        if (mac_sof) begin
            st_d.busy = 1'b1;
        end else if (mac_eof) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_busy   = st_q.busy;
    assign head_word = empty_w ? EMPTY_WORD : head_entry;
endmodule

// File: rtl/rxstat_queue_chk.sv
module rxstat_queue_chk #(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       mac_sof,
    input logic                       mac_eof,
    input logic                       discard_w,
    input logic                       flush_w,
    input logic [15:0]                head_word,
    input logic                       q_full,
    input logic                       rx_busy,
    input logic [$clog2(DEPTH+1)-1:0] occ_w
);
    AST_EMPTY_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_w == 0) |-> (head_word == 16'h8000)); // R1

    AST_STORED_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_w != 0) |-> !head_word[15]); // R2

    AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_w != 0) |-> (head_word[10:0] <= 11'd1514)); // R4

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && mac_eof && !discard_w && !flush_w) |=> (q_full && $stable(head_word))); // R5

    AST_DISCARD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && discard_w && !flush_w) |=> !q_full); // R6

    AST_EMPTY_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_w == 0 && discard_w && !mac_eof && !flush_w) |=> (occ_w == 0)); // R7

    AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flush_w |=> (occ_w == 0 && !q_full)); // R8

    AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_busy) |-> $past(mac_sof)); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ_w <= DEPTH); // R5
endmodule

bind rxstat_queue rxstat_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mac_sof   (mac_sof),
    .mac_eof   (mac_eof),
    .discard_w (discard_w),
    .flush_w   (flush_w),
    .head_word (head_word),
    .q_full    (q_full),
    .rx_busy   (rx_busy),
    .occ_w     (occ_w)
);

// File: tb/test_rxstat_queue.sv
module test_rxstat_queue;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mac_sof = 1'b0, mac_eof = 1'b0;
    logic [3:0]  mac_err = '0;
    logic [10:0] mac_len = '0;
    logic        cmd_valid = 1'b0;
    logic [4:0]  cmd_op = '0;
    logic [15:0] head_word;
    logic        q_full, rx_busy;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp_q[$];

    always #5 clk = ~clk;

    rxstat_queue #(.DEPTH(DEPTH)) i_rxstat_queue (
        .clk(clk), .rst_n(rst_n), .mac_sof(mac_sof), .mac_eof(mac_eof),
        .mac_err(mac_err), .mac_len(mac_len), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .head_word(head_word), .q_full(q_full), .rx_busy(rx_busy)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_word(input logic [3:0] e, input logic [10:0] l);
        logic [3:0]  c;
        logic [10:0] n;
        c = (e inside {4'b0010, 4'b1000, 4'b1001, 4'b1011, 4'b1100, 4'b1101}) ? e : 4'b0000;
        n = (l > 11'd1514) ? 11'd1514 : l;
        return {1'b0, c, n};
    endfunction

    function automatic logic [15:0] exp_head();
        return (exp_q.size() == 0) ? 16'h8000 : exp_q[0];
    endfunction

    // Monitor-side comparison of the visible head and full flag against the model.
    task automatic check_state(input string req);
        chk(head_word == exp_head(), req, head_word, exp_head());
        chk(q_full == (exp_q.size() == DEPTH), {req, " full"}, 16'(q_full), 16'(exp_q.size() == DEPTH));
    endtask

    // Driver: one frame with a start strobe then an end strobe.
    task automatic push_frame(input logic [3:0] e, input logic [10:0] l, input string req);
        @(negedge clk);
        mac_sof = 1'b1;
        @(negedge clk);
        mac_sof = 1'b0;
        chk(rx_busy == 1'b1, "R9 busy after sof", 16'(rx_busy), 16'h1);
        mac_eof = 1'b1; mac_err = e; mac_len = l;
        if (exp_q.size() < DEPTH) exp_q.push_back(model_word(e, l));
        @(negedge clk);
        mac_eof = 1'b0;
        chk(rx_busy == 1'b0, "R9 idle after eof", 16'(rx_busy), 16'h0);
        check_state(req);
    endtask

    task automatic command(input logic [4:0] op, input string req);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        if (op == 5'd8) begin
            chk(head_word == exp_head(), {req, " popped word"}, head_word, exp_head());
            if (exp_q.size() > 0) void'(exp_q.pop_front());
        end else if (op == 5'd5) begin
            exp_q.delete();
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        check_state(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_state("R1 reset");
        chk(rx_busy == 1'b0, "R1 busy", 16'(rx_busy), 16'h0);
        rst_n = 1'b1;

        push_frame(4'b0000, 11'd64, "R2 first word");
        push_frame(4'b1101, 11'd100, "R3 crc");
        push_frame(4'b0010, 11'd333, "R3 dribble");
        push_frame(4'b0111, 11'd77, "R3 unknown class");
        push_frame(4'b0000, 11'd2000, "R4 clamp");
        push_frame(4'b1000, 11'd1514, "R3 overrun");
        push_frame(4'b1011, 11'd10, "R3 runt");
        push_frame(4'b1100, 11'd0, "R3 alignment");
        chk(q_full == 1'b1, "R5 full at depth", 16'(q_full), 16'h1);
        push_frame(4'b1001, 11'd1600, "R5 dropped when full");

        command(5'd8, "R6 discard from full");
        chk(q_full == 1'b0, "R6 full clears", 16'(q_full), 16'h0);

        // Push and discard in the same cycle while not full.
        @(negedge clk);
        mac_eof = 1'b1; mac_err = 4'b1001; mac_len = 11'd1515;
        cmd_valid = 1'b1; cmd_op = 5'd8;
        chk(head_word == exp_head(), "R10 popped word", head_word, exp_head());
        void'(exp_q.pop_front());
        exp_q.push_back(model_word(4'b1001, 11'd1515));
        @(negedge clk);
        mac_eof = 1'b0; cmd_valid = 1'b0;
        check_state("R10 push and discard");

        command(5'd3, "R11 other opcode");
        command(5'd0, "R11 opcode zero");

        while (exp_q.size() > 0) command(5'd8, "R2 drain order");
        command(5'd8, "R7 discard on empty");
        push_frame(4'b1100, 11'd42, "R7 push after empty discard");
        command(5'd8, "R7 single drain");

        push_frame(4'b0000, 11'd5, "R8 preload a");
        push_frame(4'b1101, 11'd6, "R8 preload b");
        push_frame(4'b1000, 11'd7, "R8 preload c");
        command(5'd5, "R8 receive reset");
        push_frame(4'b1011, 11'd9, "R8 push after reset");

        // Simultaneous start and end strobes keep the busy flag set.
        @(negedge clk);
        mac_sof = 1'b1; mac_eof = 1'b1; mac_err = 4'b0000; mac_len = 11'd12;
        exp_q.push_back(model_word(4'b0000, 11'd12));
        @(negedge clk);
        mac_sof = 1'b0; mac_eof = 1'b0;
        chk(rx_busy == 1'b1, "R9 sof wins", 16'(rx_busy), 16'h1);
        check_state("R9 combined strobe push");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule